// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the processor-facing register front end of a two-channel serial communications controller. A byte-wide bus with a 3-bit address reaches each channel through two ports. The control port uses indirect addressing. A first control write loads a register pointer and may also carry a command. The next control access then writes the selected write register or returns the selected read register, and afterwards the pointer goes back to zero. The data port reaches the single-byte transmit and receive holding registers.

Each channel holds sixteen write registers, a status register, a fixed capability register and its two interrupt pending flags. A write to register 9 carries reset commands for one channel or for both. Transmit and receive are plain byte strobes, with no serialisation. Break events are latched into the status register. The two channels' gated interrupt sources are merged onto one shared, registered interrupt line.

Top module: `dscc_regs`

## Requirements
- R1: Address bit 2 selects the channel (0 = first, 1 = second) and address bit 1 selects the control port (0) or the data port (1). Address bit 0 must be 0. An access with bit 0 set reads as 0x00 and its write has no effect.
- R2: While a channel's pointer is 0, a control write loads the pointer from data bits 2:0. If data bits 5:3 equal 001, 8 is added to form pointers 8 to 15. A control read with the pointer at 0 returns the status register (RR0).
- R3: While the pointer is non-zero, a control write stores the byte into the write register the pointer selects (except register 9), and a control read returns the selected read register. Pointer 0 selects RR0, pointer 1 selects the capability register, and every other pointer reads as 0x00. Both kinds of access return the pointer to 0.
- R4: A pointer-setting control write whose bits 5:3 equal 100 clears the receive pending flag, and one whose bits 5:3 equal 101 clears the transmit pending flag. If an event sets the same flag in the same cycle, the set wins.
- R5: A write to register 9 is never stored. Its bits 7:6 act as follows: 01 resets the second channel, 10 resets the first channel, 11 resets both, and 00 does nothing. The writing channel's pointer returns to 0, and a channel that is not reset keeps its state.
- R6: A reset loads these values: write register 4 = 0x04, 9 = 0xC0, 11 = 0x08, 14 = 0x30, 15 = 0xF8, all other write registers = 0, RR0 = 0x44, capability = 0x06, pointer 0, holding registers 0, pending flags clear. The hard reset also clears the read data and the interrupt output, which are 0 in the cycle after reset.
- R7: A data-port write is taken only when bit 3 of write register 5 is set. When taken, the byte appears on that channel's tx_data with a one-cycle tx_stb in the following cycle, and the transmit pending flag is set.
- R8: rx_ready is high when bit 0 of write register 3 is set and RR0 bit 0 is clear. A strobe while ready latches the byte, sets RR0 bit 0 and sets the receive pending flag. A data-port read returns the latched byte and clears RR0 bit 0.
- R9: A break strobe sets RR0 bit 7. Only a reset clears it.
- R10: A channel requests an interrupt when write register 1 bit 0 is set and at least one of these holds: bit 1 is set with transmit pending; bits 4:3 equal 01 or 10 with receive pending; or write register 15 bit 7 and RR0 bit 7 are both set.
- R11: irq is a register holding the OR of both channels' requests, taken from the state before each clock edge.
- R12: bus_rdata is registered. It takes the read value in the cycle after a read and holds at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Channel, port and alignment bits |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_stb | output | 2 | Per-channel transmit strobe |
| tx_data | output | 16 | Per-channel transmit byte, channel n at bits 8n+7:8n |
| rx_stb | input | 2 | Per-channel receive strobe |
| rx_data | input | 16 | Per-channel received byte, same packing |
| rx_ready | output | 2 | Per-channel receive acceptance |
| brk_in | input | 2 | Per-channel break strobe |
| irq | output | 1 | Shared registered interrupt |

## Verification
The bench builds the block with its defaults: a byte-wide bus, a 3-bit address and a bank of sixteen write registers. This puts both pointer halves within reach, including the reset-command register, and exercises the two-channel reset cross-coupling through register 9. Long random runs then mix pointer commands, reset codes, enable bits and receive and break strobes on both channels. These runs hit same-cycle collisions between a clear command and a new pending event, and between reads and new receptions.

// File: rtl/dscc_pkg.sv
package dscc_pkg;
  localparam int NCH = 2;

  // write register indices whose bits drive behaviour
  localparam int WR_IE  = 1;
  localparam int WR_RXC = 3;
  localparam int WR_TXC = 5;
  localparam int WR_RST = 9;
  localparam int WR_XIE = 15;

  // commands carried in bits 5:3 of a pointer-setting write
  localparam logic [2:0] CMD_HIGH   = 3'b001;
  localparam logic [2:0] CMD_RX_CLR = 3'b100;
  localparam logic [2:0] CMD_TX_CLR = 3'b101;

  localparam logic [7:0] RR0_INIT = 8'h44;
  localparam logic [7:0] RR1_INIT = 8'h06;

  function automatic logic [7:0] wr_init(int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dscc_chan.sv
module dscc_chan
  import dscc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          ctl_wr,
  input  logic          ctl_rd,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] wdata,
  input  logic          rx_stb,
  input  logic [DW-1:0] rx_byte,
  input  logic          brk_in,
  output logic [DW-1:0] ctl_rval,
  output logic [DW-1:0] dat_rval,
  output logic          tx_stb,
  output logic [DW-1:0] tx_byte,
  output logic          rx_ready,
  output logic [1:0]    rst_req,
  output logic          int_cond
);
  localparam int PW = $clog2(NREG);

  logic [DW-1:0] wr [NREG];
  logic [PW-1:0] ptr;
  logic [DW-1:0] rr0, rr1, rx_hold;
  logic          rx_pend, tx_pend;
  logic [2:0]    cmd;
  logic          ptr_zero, rx_mode_on;

  assign cmd      = wdata[5:3];
  assign ptr_zero = (ptr == '0);
  assign dat_rval = rx_hold;
  assign rx_ready = wr[WR_RXC][0] & ~rr0[0];

  always_comb begin
    if (ptr_zero)             ctl_rval = rr0;
    else if (ptr == PW'(1))   ctl_rval = rr1;
    else                      ctl_rval = '0;
  end

  // bit 7 of the reset field asks for the first channel, bit 6 the second
  always_comb begin
    rst_req = 2'b00;
    if (ctl_wr && (ptr == PW'(WR_RST))) rst_req = {wdata[6], wdata[7]};
  end

  assign rx_mode_on = wr[WR_IE][4] ^ wr[WR_IE][3];
  assign int_cond = wr[WR_IE][0] &
                    ((wr[WR_IE][1] & tx_pend) |
                     (rx_mode_on & rx_pend) |
                     (wr[WR_XIE][7] & rr0[7]));

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < NREG; i++) wr[i] <= DW'(wr_init(i));
      ptr     <= '0;
      rr0     <= DW'(RR0_INIT);
      rr1     <= DW'(RR1_INIT);
      rx_hold <= '0;
      tx_byte <= '0;
      tx_stb  <= 1'b0;
      rx_pend <= 1'b0;
      tx_pend <= 1'b0;
    end else begin
      tx_stb <= 1'b0;
      if (ctl_wr) begin
        if (ptr_zero) begin
          ptr <= {cmd == CMD_HIGH, wdata[PW-2:0]};
          if (cmd == CMD_RX_CLR) rx_pend <= 1'b0;
          if (cmd == CMD_TX_CLR) tx_pend <= 1'b0;
        end else begin
          if (ptr != PW'(WR_RST)) wr[ptr] <= wdata;
          ptr <= '0;
        end
      end else if (ctl_rd) begin
        ptr <= '0;
      end
      if (dat_wr && wr[WR_TXC][3]) begin
        tx_byte <= wdata;
        tx_stb  <= 1'b1;
        tx_pend <= 1'b1;
      end
      if (dat_rd) rr0[0] <= 1'b0;
      if (rx_stb && rx_ready) begin
        rr0[0]  <= 1'b1;
        rx_hold <= rx_byte;
        rx_pend <= 1'b1;
      end
      if (brk_in) rr0[7] <= 1'b1;
    end
  end
endmodule

// File: rtl/dscc_irq.sv
module dscc_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] cond,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |cond;
  end
endmodule

// File: rtl/dscc_regs.sv
module dscc_regs
  import dscc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int NREG = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    tx_stb,
  output logic [NCH*DW-1:0] tx_data,
  input  logic [NCH-1:0]    rx_stb,
  input  logic [NCH*DW-1:0] rx_data,
  output logic [NCH-1:0]    rx_ready,
  input  logic [NCH-1:0]    brk_in,
  output logic              irq
);
  logic              addr_ok, is_data, ch;
  logic [NCH-1:0]    sel, chan_clr, conds;
  logic [1:0]        req [NCH];
  logic [DW-1:0]     ctl_rv [NCH];
  logic [DW-1:0]     dat_rv [NCH];

  assign addr_ok = ~bus_addr[0];
  assign is_data = bus_addr[1];
  assign ch      = bus_addr[AW-1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign sel[g]      = bus_cs & addr_ok & (ch == 1'(g));
    assign chan_clr[g] = rst | req[0][g] | req[1][g];

    dscc_chan #(.DW(DW), .NREG(NREG)) u_chan (
      .clk      (clk),
      .clr      (chan_clr[g]),
      .ctl_wr   (sel[g] & bus_we & ~is_data),
      .ctl_rd   (sel[g] & ~bus_we & ~is_data),
      .dat_wr   (sel[g] & bus_we & is_data),
      .dat_rd   (sel[g] & ~bus_we & is_data),
      .wdata    (bus_wdata),
      .rx_stb   (rx_stb[g]),
      .rx_byte  (rx_data[g*DW +: DW]),
      .brk_in   (brk_in[g]),
      .ctl_rval (ctl_rv[g]),
      .dat_rval (dat_rv[g]),
      .tx_stb   (tx_stb[g]),
      .tx_byte  (tx_data[g*DW +: DW]),
      .rx_ready (rx_ready[g]),
      .rst_req  (req[g]),
      .int_cond (conds[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_cs && !bus_we) begin
      if (!addr_ok)     bus_rdata <= '0;
      else if (is_data) bus_rdata <= dat_rv[ch];
      else              bus_rdata <= ctl_rv[ch];
    end
  end

  dscc_irq #(.NSRC(NCH)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .cond (conds),
    .irq  (irq)
  );
endmodule

// File: rtl/dscc_regs_chk.sv
module dscc_regs_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_cs,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic [1:0]    tx_stb,
  input logic [1:0]    rx_stb,
  input logic [1:0]    rx_ready,
  input logic          irq
);
  AST_UNALIGNED_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_cs && !bus_we && bus_addr[0]) |-> bus_rdata == '0); // R1

  AST_IRQ_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(bus_rdata)) |-> $past(bus_cs && !bus_we)); // R12

  for (genvar i = 0; i < 2; i++) begin : g_ck
    AST_TX_CAUSE: assert property (@(posedge clk) disable iff (rst)
      tx_stb[i] |-> $past(bus_cs && bus_we && bus_addr[AW-1] == 1'(i) &&
                          bus_addr[1:0] == 2'b10)); // R7

    AST_RX_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (rx_stb[i] && rx_ready[i]) |=> !rx_ready[i]); // R8
  end
endmodule

bind dscc_regs dscc_regs_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_cs    (bus_cs),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .tx_stb    (tx_stb),
  .rx_stb    (rx_stb),
  .rx_ready  (rx_ready),
  .irq       (irq)
);

// File: tb/dscc_regs_bench.sv
module dscc_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cs = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  tx_stb, rx_stb = '0, rx_ready, brk_in = '0;
  logic [15:0] tx_data, rx_data = '0;
  logic        irq;

  always #10 clk = ~clk;

  dscc_regs u_dscc_regs (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_stb(tx_stb), .tx_data(tx_data),
    .rx_stb(rx_stb), .rx_data(rx_data), .rx_ready(rx_ready), .brk_in(brk_in), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state derived from the requirements
  logic [7:0] m_wr [2][16];
  int         m_ptr [2];
  logic [7:0] m_rr0 [2], m_rx [2], e_txd [2];
  logic       m_rxp [2], m_txp [2];
  logic [1:0] e_txs;
  logic [7:0] e_rdata;
  logic       e_irq;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic cond(int c);
    logic [1:0] rm;
    rm = m_wr[c][1][4:3];
    return m_wr[c][1][0] & ((m_wr[c][1][1] & m_txp[c]) |
           (((rm == 2'b01) || (rm == 2'b10)) & m_rxp[c]) |
           (m_wr[c][15][7] & m_rr0[c][7]));
  endfunction

  task automatic reset_chan(int c);
    for (int i = 0; i < 16; i++) m_wr[c][i] = 8'h00;
    m_wr[c][4] = 8'h04; m_wr[c][9] = 8'hC0; m_wr[c][11] = 8'h08;
    m_wr[c][14] = 8'h30; m_wr[c][15] = 8'hF8;
    m_ptr[c] = 0; m_rr0[c] = 8'h44; m_rx[c] = 8'h00;
    m_rxp[c] = 0; m_txp[c] = 0; e_txd[c] = 8'h00; e_txs[c] = 1'b0;
  endtask

  task automatic cycle(input logic cs, input logic we, input logic [2:0] a, input logic [7:0] wd,
                       input logic [1:0] rs, input logic [7:0] rd0, input logic [7:0] rd1,
                       input logic [1:0] bk);
    logic [1:0] rdy, clrq;
    logic [2:0] cmd;
    int ch;
    string rtag;
    bus_cs = cs; bus_we = we; bus_addr = a; bus_wdata = wd;
    rx_stb = rs; rx_data = {rd1, rd0}; brk_in = bk;
    e_irq = cond(0) | cond(1);
    for (int c = 0; c < 2; c++) rdy[c] = m_wr[c][3][0] & ~m_rr0[c][0];
    clrq = 2'b00; e_txs = 2'b00; rtag = "R12";
    ch = int'(a[2]);
    cmd = wd[5:3];
    if (cs && !we) begin
      if (a[0]) begin e_rdata = 8'h00; rtag = "R1"; end
      else if (a[1]) begin e_rdata = m_rx[ch]; m_rr0[ch][0] = 1'b0; rtag = "R8"; end
      else begin
        e_rdata = (m_ptr[ch] == 0) ? m_rr0[ch] : ((m_ptr[ch] == 1) ? 8'h06 : 8'h00);
        rtag = (m_ptr[ch] == 0) ? "R2" : "R3";
        m_ptr[ch] = 0;
      end
    end else if (cs && we && !a[0]) begin
      if (a[1]) begin
        if (m_wr[ch][5][3]) begin e_txd[ch] = wd; e_txs[ch] = 1'b1; m_txp[ch] = 1'b1; end
      end else if (m_ptr[ch] == 0) begin
        m_ptr[ch] = (cmd == 3'b001) ? 8 + int'(wd[2:0]) : int'(wd[2:0]);
        if (cmd == 3'b100) m_rxp[ch] = 1'b0;
        if (cmd == 3'b101) m_txp[ch] = 1'b0;
      end else begin
        if (m_ptr[ch] == 9) clrq = {wd[6], wd[7]};
        else m_wr[ch][m_ptr[ch]] = wd;
        m_ptr[ch] = 0;
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (rs[c] && rdy[c]) begin
        m_rr0[c][0] = 1'b1; m_rx[c] = (c == 0) ? rd0 : rd1; m_rxp[c] = 1'b1;
      end
      if (bk[c]) m_rr0[c][7] = 1'b1;
    end
    for (int c = 0; c < 2; c++) if (clrq[c]) reset_chan(c);
    @(posedge clk);
    @(negedge clk);
    chk(rtag, "rdata", bus_rdata, e_rdata);
    chk("R11", "irq", irq, e_irq);
    for (int c = 0; c < 2; c++) begin
      chk("R7", "tx_stb", tx_stb[c], e_txs[c]);
      chk("R7", "tx_data", tx_data[c*8 +: 8], e_txd[c]);
      chk("R8", "rx_ready", rx_ready[c], m_wr[c][3][0] & ~m_rr0[c][0]);
    end
  endtask

  task automatic cw(int c, logic [7:0] v); cycle(1, 1, {c[0], 2'b00}, v, 0, 0, 0, 0); endtask
  task automatic cr(int c);                cycle(1, 0, {c[0], 2'b00}, 0, 0, 0, 0, 0); endtask
  task automatic dw(int c, logic [7:0] v); cycle(1, 1, {c[0], 2'b10}, v, 0, 0, 0, 0); endtask
  task automatic dr(int c);                cycle(1, 0, {c[0], 2'b10}, 0, 0, 0, 0, 0); endtask
  task automatic idle();                   cycle(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wreg(int c, int r, logic [7:0] v);
    cw(c, (r >= 8) ? (8'h08 | 8'(r - 8)) : 8'(r));
    cw(c, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog: got %0d cycles expected fewer", 200000);
    finish_up();
  end

  initial begin
    logic [31:0] r;
    logic [2:0]  a;
    logic [7:0]  wd;
    reset_chan(0); reset_chan(1);
    e_rdata = 8'h00; e_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R6: state right after reset
    chk("R6", "irq", irq, 0);
    chk("R6", "rdata", bus_rdata, 0);
    chk("R6", "rx_ready", rx_ready, 0);
    chk("R6", "tx_stb", tx_stb, 0);
    cr(0); chk("R6", "rr0", bus_rdata, 8'h44);
    cw(1, 8'h01); cr(1); chk("R6", "rr1", bus_rdata, 8'h06);
    cw(0, 8'h03); cr(0); chk("R3", "unused rr", bus_rdata, 8'h00);
    // R7: data write ignored until transmit enable
    dw(0, 8'h11); chk("R7", "gated tx", tx_stb, 0);
    wreg(0, 5, 8'h08);
    dw(0, 8'hA5); chk("R7", "tx pulse", tx_stb, 2'b01); chk("R7", "tx byte", tx_data[7:0], 8'hA5);
    // R10: transmit interrupt, then R4 clear command
    wreg(0, 1, 8'h03); idle(); chk("R10", "tx irq", irq, 1);
    cw(0, 8'h28); idle(); chk("R4", "tx clear", irq, 0);
    // R8: receive on second channel
    wreg(1, 3, 8'h01); chk("R8", "ready", rx_ready[1], 1);
    cycle(0, 0, 0, 0, 2'b10, 0, 8'h3C, 0); chk("R8", "taken", rx_ready[1], 0);
    cycle(0, 0, 0, 0, 2'b10, 0, 8'h77, 0);
    cr(1); chk("R8", "rr0 avail", bus_rdata, 8'h45);
    dr(1); chk("R8", "rx byte", bus_rdata, 8'h3C);
    cr(1); chk("R8", "rr0 clear", bus_rdata, 8'h44);
    // R9: break, plus shared interrupt (R11)
    wreg(1, 1, 8'h01);
    cycle(0, 0, 0, 0, 0, 0, 0, 2'b10);
    cr(1); chk("R9", "break bit", bus_rdata, 8'hC4);
    idle(); chk("R11", "shared irq", irq, 1);
    // R2: upper bank pointer reaches register 15
    wreg(1, 15, 8'h00); idle(); chk("R2", "wr15 cleared", irq, 0);
    cr(1); chk("R9", "break kept", bus_rdata, 8'hC4);
    // R5: first channel resets second channel only
    wreg(0, 9, 8'h40);
    cr(1); chk("R5", "ch1 rr0", bus_rdata, 8'h44);
    chk("R5", "ch1 ready", rx_ready[1], 0);
    dw(0, 8'h5A); chk("R5", "ch0 kept", tx_stb, 2'b01);
    cr(0); chk("R5", "writer ptr", bus_rdata, 8'h44);
    wreg(0, 9, 8'hC0);
    dw(0, 8'h66); chk("R5", "both reset", tx_stb, 0);
    // R1: unaligned accesses
    wreg(0, 5, 8'h08);
    cycle(1, 1, 3'b011, 8'h99, 0, 0, 0, 0); chk("R1", "write ignored", tx_stb, 0);
    cycle(1, 0, 3'b001, 0, 0, 0, 0, 0); chk("R1", "read zero", bus_rdata, 0);
    // R4: set wins against a same-cycle clear
    wreg(0, 3, 8'h01); wreg(0, 1, 8'h09);
    cycle(1, 1, 3'b000, 8'h20, 2'b01, 8'h42, 0, 0);
    idle(); chk("R4", "set wins", irq, 1);
    // random phase
    void'($urandom(32'd20240607));
    for (int c = 0; c < 2; c++) begin wreg(c, 5, 8'h08); wreg(c, 3, 8'h01); wreg(c, 1, 8'h0B); end
    for (int n = 0; n < 4000; n++) begin
      r = $urandom;
      a = {r[0], r[1], (r[5:2] == 4'h0)};
      wd = r[23:16];
      if (r[8] && !a[1] && m_ptr[int'(a[2])] == 9 && r[12:9] != 4'h0) wd[7:6] = 2'b00;
      cycle(r[6] | r[7], r[8], a, wd, {r[26] & r[27], r[24] & r[25]}, r[15:8], r[31:24],
            {&r[31:27], &r[13:9]});
    end
    idle();
    finish_up();
  end
endmodule